// File: doc/BRIEF.md
# External Memory Bus Byte/Word Controller

This block sits between a CPU's word-addressed request port and a parallel external memory bus. It decodes each CPU word address into one of four active-low chip selects. It then runs one or two timed read or write cycles on the bus and returns a one-clock ready pulse together with the read word. Addresses below the external window complete at once, with no bus activity.

Three straps set the bus behaviour. `width16` selects a 16-bit data bus (1) or an 8-bit data bus (0). On the 8-bit bus, `pair_en` selects between two options: assembling each 16-bit word from two consecutive byte cycles, or single-byte accesses. `cs3_addr_en` turns the highest chip-select pin into byte-address bit 23, so that one device covers both upper regions. The straps and the request fields are captured when a request is accepted. The bus is modelled as split data lines (`ed_o`, `ed_oe`, `ed_i`) rather than a bidirectional port.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all four chip selects, `rd_n` and `wr_n` are high, `ready` is low and `ed_oe` is 0.
- R2: With `cs3_addr_en`=0, word addresses 0x0200000–0x03FFFFF select `cs_n[0]`, 0x0400000–0x07FFFFF select `cs_n[1]`, 0x0800000–0x0BFFFFF select `cs_n[2]` and 0x0C00000–0x0FFFFFF select `cs_n[3]`. The device offset is the address minus the region's base.
- R3: A request below 0x0200000 produces no strobe on any pin and returns `ready` one clock after acceptance, with `rdata`=0.
- R4: Word mode (`width16`=1) performs one cycle at bus address = offset, reads all 16 data lines, and on writes drives `ed_o`=wdata with `ed_oe`=2'b11.
- R5: Byte-pair mode (`width16`=0, `pair_en`=1) performs two cycles at byte addresses 2·offset and 2·offset+1. The first cycle supplies `rdata[7:0]` and the second `rdata[15:8]`, taken from `ed_i[7:0]` only. On writes, `ed_o[7:0]` carries `wdata[7:0]` and then `wdata[15:8]`, with `ed_oe`=2'b01.
- R6: Single-byte mode (`width16`=0, `pair_en`=0) performs one cycle at bus address = offset[21:0], with `ea[22]` held at 0. It returns `rdata`={8'h00, ed_i[7:0]}, and on writes drives `wdata[7:0]` with `ed_oe`=2'b01.
- R7: Each bus cycle holds its chip select and either RD or WR low for exactly STROBE_CYC clocks, with `ea` stable. One idle clock separates consecutive cycles.
- R8: `ready` is a one-clock pulse. For an access of n bus cycles it becomes visible n·(STROBE_CYC+1)+1 clock samples after the request is raised. Writes return `rdata`=0.
- R9: With `cs3_addr_en`=1, the whole range 0x0800000–0x0FFFFFF selects `cs_n[2]` with offset = address − 0x0800000. During a strobe, the `cs_n[3]` pin carries bus-address bit 23.
- R10: `rd_n` and `wr_n` are never low together, at most one chip select is active, and `ed_oe` is nonzero only while `wr_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| width16 | input | 1 | Bus width strap: 1 = 16-bit, 0 = 8-bit |
| pair_en | input | 1 | On 8-bit bus: 1 = assemble words from byte pairs, 0 = single-byte accesses |
| cs3_addr_en | input | 1 | Repurpose the top chip-select pin as byte-address bit 23 |
| req | input | 1 | CPU request, sampled while the block is idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 24 | CPU word address |
| wdata | input | 16 | CPU write data |
| ready | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid with ready |
| ea | output | 23 | External address lines |
| ed_o | output | 16 | External data driven on writes |
| ed_oe | output | 2 | Output enable per byte lane (bit 0 = lines 7..0) |
| ed_i | input | 16 | External data sampled on reads |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| cs_n | output | 4 | Active-low chip selects; bit 3 doubles as address bit 23 |

## Verification
Some properties are checked on every clock: the exclusiveness of the strobes and chip selects, the exact strobe length, address stability during a strobe, the single-clock ready pulse, and the restriction to the low byte lane in 8-bit mode. Other behaviour can only be shown by the bench scenarios, which compare against a bench-side memory model: which chip select a given address reaches, the byte-address arithmetic of each mode, the low/high order of assembled bytes, the overall latency, and the routing of the repurposed pin.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  localparam int CPU_AW = 24;
  localparam int DATA_W = 16;
  localparam int BYTE_W = DATA_W / 2;
  localparam int EA_W   = 23;
  localparam int OFF_W  = EA_W;
  localparam int BUS_AW = EA_W + 1;
  localparam int CS_N   = 4;
  localparam int SEL_W  = $clog2(CS_N);

  typedef enum logic [1:0] {BM_WORD, BM_PAIR, BM_BYTE} bus_mode_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_STB, SQ_GAP} seq_state_e;

  typedef struct packed {
    logic             hit;
    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] off;
  } dec_t;

  // word address -> device select and device word offset
  function automatic dec_t region_decode(logic [CPU_AW-1:0] a, logic merge);
    dec_t d;
    d.hit = 1'b1;
    d.sel = '0;
    d.off = '0;
    if (a[23:21] == 3'b000) begin
      d.hit = 1'b0;
    end else if (a[23:22] == 2'b00) begin
      d.sel = SEL_W'(0);
      d.off = {2'b00, a[20:0]};
    end else if (!a[23]) begin
      d.sel = SEL_W'(1);
      d.off = {1'b0, a[21:0]};
    end else if (merge) begin
      d.sel = SEL_W'(2);
      d.off = a[22:0];
    end else begin
      d.sel = a[22] ? SEL_W'(3) : SEL_W'(2);
      d.off = {1'b0, a[21:0]};
    end
    return d;
  endfunction

  function automatic bus_mode_e pick_mode(logic w16, logic pair);
    if (w16)  return BM_WORD;
    if (pair) return BM_PAIR;
    return BM_BYTE;
  endfunction

  // device offset and byte index -> address placed on the bus
  function automatic logic [BUS_AW-1:0] bus_address(bus_mode_e m, logic [OFF_W-1:0] off, logic idx);
    case (m)
      BM_WORD: return {1'b0, off};
      BM_PAIR: return {off, idx};
      default: return {2'b00, off[OFF_W-2:0]};
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_drive(bus_mode_e m, logic idx, logic [DATA_W-1:0] wd);
    if (m == BM_WORD) return wd;
    return {{BYTE_W{1'b0}}, (idx ? wd[DATA_W-1:BYTE_W] : wd[BYTE_W-1:0])};
  endfunction
endpackage

// File: rtl/ebus_decode.sv
module ebus_decode import ebus_pkg::*; (
  input  logic [CPU_AW-1:0] addr,
  input  logic              merge,
  output logic              hit,
  output logic [SEL_W-1:0]  sel,
  output logic [OFF_W-1:0]  off
);
  dec_t d;
  always_comb begin
    d   = region_decode(addr, merge);
    hit = d.hit;
    sel = d.sel;
    off = d.off;
  end
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq import ebus_pkg::*; #(
  parameter int STROBE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic two,
  output logic strobe,
  output logic cap,
  output logic idx,
  output logic done,
  output logic idle
);
  localparam int CW = $clog2(STROBE_CYC + 1);

  seq_state_e    st;
  logic [CW-1:0] cnt;
  logic          two_q;

  assign strobe = (st == SQ_STB);
  assign cap    = strobe && (cnt == CW'(STROBE_CYC - 1));
  assign done   = (st == SQ_GAP) && !(two_q && !idx);
  assign idle   = (st == SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      idx   <= 1'b0;
      two_q <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          st    <= SQ_STB;
          cnt   <= '0;
          idx   <= 1'b0;
          two_q <= two;
        end
        SQ_STB: if (cap) st <= SQ_GAP;
                else     cnt <= cnt + 1'b1;
        SQ_GAP: if (two_q && !idx) begin
          idx <= 1'b1;
          cnt <= '0;
          st  <= SQ_STB;
        end else begin
          st <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ebus_lane.sv
module ebus_lane import ebus_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_mode_e         mode,
  input  logic              idx,
  input  logic              cap,
  input  logic              strobe,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ed_i,
  output logic [DATA_W-1:0] ed_o,
  output logic [1:0]        ed_oe,
  output logic [DATA_W-1:0] rword
);
  assign ed_o  = lane_drive(mode, idx, wdata);
  assign ed_oe = (strobe && we) ? ((mode == BM_WORD) ? 2'b11 : 2'b01) : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rword <= '0;
    end else if (cap) begin
      case (mode)
        BM_WORD: rword <= ed_i;
        BM_PAIR: if (idx) rword[DATA_W-1:BYTE_W] <= ed_i[BYTE_W-1:0];
                 else     rword[BYTE_W-1:0]      <= ed_i[BYTE_W-1:0];
        default: rword <= {{BYTE_W{1'b0}}, ed_i[BYTE_W-1:0]};
      endcase
    end
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl import ebus_pkg::*; #(
  parameter int STROBE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              width16,
  input  logic              pair_en,
  input  logic              cs3_addr_en,
  input  logic              req,
  input  logic              we,
  input  logic [CPU_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic [EA_W-1:0]   ea,
  output logic [DATA_W-1:0] ed_o,
  output logic [1:0]        ed_oe,
  input  logic [DATA_W-1:0] ed_i,
  output logic              rd_n,
  output logic              wr_n,
  output logic [CS_N-1:0]   cs_n
);
  logic              dec_hit;
  logic [SEL_W-1:0]  dec_sel;
  logic [OFF_W-1:0]  dec_off;
  bus_mode_e         req_mode, mode_q;
  logic              merge_q, we_q, rdy_q;
  logic [SEL_W-1:0]  sel_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rword;
  logic              accept, strobe, cap, idx, seq_done, seq_idle;
  logic [BUS_AW-1:0] baddr;

  ebus_decode u_dec (
    .addr(addr), .merge(cs3_addr_en), .hit(dec_hit), .sel(dec_sel), .off(dec_off)
  );

  assign req_mode = pick_mode(width16, pair_en);
  assign accept   = req && seq_idle && !rdy_q;

  ebus_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept && dec_hit), .two(req_mode == BM_PAIR),
    .strobe(strobe), .cap(cap), .idx(idx), .done(seq_done), .idle(seq_idle)
  );

  ebus_lane u_lane (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .idx(idx), .cap(cap), .strobe(strobe),
    .we(we_q), .wdata(wdata_q), .ed_i(ed_i), .ed_o(ed_o), .ed_oe(ed_oe), .rword(rword)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= BM_WORD;
      merge_q <= 1'b0;
      we_q    <= 1'b0;
      sel_q   <= '0;
      off_q   <= '0;
      wdata_q <= '0;
      rdy_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rdy_q <= seq_done || (accept && !dec_hit);
      if (accept) begin
        mode_q  <= req_mode;
        merge_q <= cs3_addr_en;
        we_q    <= we;
        sel_q   <= dec_sel;
        off_q   <= dec_off;
        wdata_q <= wdata;
      end
      if (accept && !dec_hit) rdata_q <= '0;
      else if (seq_done)      rdata_q <= we_q ? '0 : rword;
    end
  end

  assign baddr = bus_address(mode_q, off_q, idx);
  assign ea    = baddr[EA_W-1:0];
  assign rd_n  = !(strobe && !we_q);
  assign wr_n  = !(strobe && we_q);
  assign ready = rdy_q;
  assign rdata = rdata_q;

  for (genvar i = 0; i < CS_N; i++) begin : g_cs
    if (i == CS_N - 1) begin : g_top
      assign cs_n[i] = merge_q ? (strobe && baddr[BUS_AW-1]) : !(strobe && sel_q == SEL_W'(i));
    end else begin : g_plain
      assign cs_n[i] = !(strobe && sel_q == SEL_W'(i));
    end
  end
endmodule

// File: rtl/ebus_chk.sv
module ebus_chk import ebus_pkg::*; #(
  parameter int STROBE_CYC = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            width16,
  input logic            cs3_addr_en,
  input logic [CS_N-1:0] cs_n,
  input logic            rd_n,
  input logic            wr_n,
  input logic [EA_W-1:0] ea,
  input logic [1:0]      ed_oe,
  input logic            ready
);
  logic       strb;
  logic [7:0] run_cnt;

  assign strb = !rd_n || !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_cnt <= '0;
    else if (!strb)             run_cnt <= '0;
    else if (run_cnt != 8'hFF)  run_cnt <= run_cnt + 8'd1;
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R10
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cs3_addr_en ? $onehot0(~cs_n[CS_N-2:0]) : $onehot0(~cs_n)); // R10
  AST_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (ed_oe != 2'b00) |-> !wr_n); // R10
  AST_STROBE_HAS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && !cs3_addr_en) |-> (cs_n != {CS_N{1'b1}})); // R10
  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(strb) |-> (run_cnt == 8'(STROBE_CYC))); // R7
  AST_STROBE_MAX: assert property (@(posedge clk) disable iff (!rst_n) strb |-> (run_cnt < 8'(STROBE_CYC))); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (strb && $past(strb)) |-> $stable(ea)); // R7
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ready |=> !ready); // R8
  AST_NARROW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (!width16 && ed_oe != 2'b00) |-> (ed_oe == 2'b01)); // R5
endmodule

bind ext_bus_ctrl ebus_chk #(.STROBE_CYC(STROBE_CYC)) u_ebus_chk (
  .clk(clk), .rst_n(rst_n), .width16(width16), .cs3_addr_en(cs3_addr_en), .cs_n(cs_n),
  .rd_n(rd_n), .wr_n(wr_n), .ea(ea), .ed_oe(ed_oe), .ready(ready)
);

// File: tb/test_ext_bus_ctrl.sv
`timescale 1ns/1ps
module test_ext_bus_ctrl;
  localparam int S = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lw16 = 1'b1, lpair = 1'b0, lmerge = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0, ed_i = '0;
  logic ready, rd_n, wr_n;
  logic [15:0] rdata, ed_o;
  logic [22:0] ea;
  logic [1:0]  ed_oe;
  logic [3:0]  cs_n;

  int checks = 0, fails = 0;

  ext_bus_ctrl #(.STROBE_CYC(S)) i_ext_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .width16(lw16), .pair_en(lpair), .cs3_addr_en(lmerge),
    .req(req), .we(we), .addr(addr), .wdata(wdata), .ready(ready), .rdata(rdata),
    .ea(ea), .ed_o(ed_o), .ed_oe(ed_oe), .ed_i(ed_i), .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // bench memory: distinct value per device and byte/word address
  function automatic logic [15:0] mem16(int dev, logic [23:0] b);
    return b[15:0] ^ {b[23:16], b[23:16] ^ 8'h5A} ^ (16'(dev) * 16'h1357 + 16'h0F0F);
  endfunction

  function automatic int pin_dev();
    int n = 0, d = -1;
    for (int i = 0; i < 4; i++) begin
      if (!(i == 3 && lmerge) && !cs_n[i]) begin n++; d = i; end
    end
    return (n > 1) ? -2 : d;
  endfunction

  // bus activity log, filled from the pins
  int          nlog = 0;
  int          log_dev[8], log_len[8];
  logic [23:0] log_ba[8];
  logic        log_we[8];
  logic [15:0] log_d[8];
  logic [1:0]  log_oe[8];
  bit          prev_stb = 1'b0;

  always @(negedge clk) begin
    bit stb;
    stb = !rd_n || !wr_n;
    if (stb && !prev_stb) begin
      if (nlog < 8) begin
        log_dev[nlog] = pin_dev();
        log_ba[nlog]  = {lmerge ? cs_n[3] : 1'b0, ea};
        log_we[nlog]  = !wr_n;
        log_d[nlog]   = ed_o;
        log_oe[nlog]  = ed_oe;
        log_len[nlog] = 1;
      end
      nlog++;
    end else if (stb && nlog >= 1 && nlog <= 8) begin
      log_len[nlog-1]++;
    end
    prev_stb = stb;
    ed_i = !rd_n ? mem16(pin_dev(), {lmerge ? cs_n[3] : 1'b0, ea}) : 16'h0000;
  end

  task automatic access(input logic wr, input logic [23:0] a, input logic [15:0] wd);
    int dev, n, k;
    logic [23:0] base, off;
    logic [23:0] ba[2];
    logic [15:0] exp_rd, lo, hi;
    string mt, dt;
    base = '0;
    if (a < 24'h200000)                       dev = -1;
    else if (a < 24'h400000) begin dev = 0; base = 24'h200000; end
    else if (a < 24'h800000) begin dev = 1; base = 24'h400000; end
    else if (lmerge || a < 24'hC00000) begin dev = 2; base = 24'h800000; end
    else begin dev = 3; base = 24'hC00000; end
    off = a - base;
    mt  = lw16 ? "R4" : (lpair ? "R5" : "R6");
    dt  = lmerge ? "R9" : "R2";
    ba[0] = '0; ba[1] = '0;
    if (dev < 0)            n = 0;
    else if (lw16)          begin n = 1; ba[0] = off; end
    else if (lpair)         begin n = 2; ba[0] = off << 1; ba[1] = (off << 1) + 24'd1; end
    else                    begin n = 1; ba[0] = off & 24'h3FFFFF; end
    lo = mem16(dev, ba[0]);
    hi = mem16(dev, ba[1]);
    if (wr || dev < 0) exp_rd = '0;
    else if (lw16)     exp_rd = lo;
    else if (lpair)    exp_rd = {hi[7:0], lo[7:0]};
    else               exp_rd = {8'h00, lo[7:0]};

    @(negedge clk);
    nlog = 0; we = wr; addr = a; wdata = wd; req = 1'b1;
    @(negedge clk);
    req = 1'b0; k = 1;
    while (!ready && k < 64) begin @(negedge clk); k++; end

    chk(k == n * (S + 1) + 1, "R8", "ready latency", k, n * (S + 1) + 1);
    chk(nlog == n, (dev < 0) ? "R3" : mt, "bus cycle count", nlog, n);
    for (int i = 0; i < n && i < nlog; i++) begin
      chk(log_dev[i] == dev, dt, "chip select", log_dev[i], dev);
      chk(log_ba[i] == ba[i], lmerge ? "R9" : mt, "bus address", log_ba[i], ba[i]);
      chk(log_len[i] == S, "R7", "strobe length", log_len[i], S);
      chk(log_we[i] == wr, "R10", "strobe kind", log_we[i], wr);
      chk(log_oe[i] == (wr ? (lw16 ? 2'b11 : 2'b01) : 2'b00), mt, "lane enable", log_oe[i],
          wr ? (lw16 ? 2'b11 : 2'b01) : 2'b00);
      if (wr) begin
        if (lw16) chk(log_d[i] == wd, mt, "write word", log_d[i], wd);
        else      chk(log_d[i][7:0] == ((i == 1) ? wd[15:8] : wd[7:0]), mt, "write byte",
                      log_d[i][7:0], (i == 1) ? wd[15:8] : wd[7:0]);
      end
    end
    chk(rdata == exp_rd, (dev < 0) ? "R3" : (wr ? "R8" : mt), "read data", rdata, exp_rd);
    @(negedge clk);
    chk(!ready, "R8", "ready single pulse", ready, 0);
  endtask

  task automatic set_mode(input logic w, input logic p, input logic m);
    @(negedge clk);
    lw16 = w; lpair = p; lmerge = m;
  endtask

  logic [23:0] edges[11] = '{24'h000000, 24'h1FFFFF, 24'h200000, 24'h3FFFFF, 24'h400000,
                             24'h7FFFFF, 24'h800000, 24'hBFFFFF, 24'hC00000, 24'hFFFFFF, 24'h5A5A5A};

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    chk(cs_n == 4'hF && rd_n && wr_n && !ready && ed_oe == 2'b00, "R1", "pins in reset",
        {cs_n, rd_n, wr_n, ready, ed_oe}, {4'hF, 1'b1, 1'b1, 1'b0, 2'b00});
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 4'hF && rd_n && wr_n && !ready && ed_oe == 2'b00, "R1", "pins after reset",
        {cs_n, rd_n, wr_n, ready, ed_oe}, {4'hF, 1'b1, 1'b1, 1'b0, 2'b00});

    // directed: region edges in each mode, reads then writes (R2, R3, R4, R5, R6)
    for (int m = 0; m < 3; m++) begin
      set_mode(m == 0, m == 1, 1'b0);
      foreach (edges[i]) access(1'b0, edges[i], 16'h0);
      foreach (edges[i]) access(1'b1, edges[i], 16'hC3A5 ^ 16'(i));
    end
    // directed: top pin as address bit 23 (R9)
    for (int m = 0; m < 3; m++) begin
      set_mode(m == 0, m == 1, 1'b1);
      foreach (edges[i]) access(1'b0, edges[i], 16'h0);
      access(1'b1, 24'hFFFFFF, 16'h9D2E);
      access(1'b1, 24'hC00001, 16'h17E8);
    end

    // random mix
    for (int t = 0; t < 200; t++) begin
      logic [23:0] a;
      int r;
      int md;
      md = int'($urandom % 3);
      set_mode(md == 0, md == 1, 1'($urandom % 2));
      r = int'($urandom % 5);
      case (r)
        0: a = 24'($urandom % 32'h200000);
        1: a = 24'h200000 + 24'($urandom % 32'h200000);
        2: a = 24'h400000 + 24'($urandom % 32'h400000);
        3: a = 24'h800000 + 24'($urandom % 32'h400000);
        default: a = 24'hC00000 + 24'($urandom % 32'h400000);
      endcase
      access(1'($urandom % 2), a, 16'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule